// File: doc/BRIEF.md
# 16-QAM Symbol Source and Raised-Cosine Shaper

This block is the baseband front of a 16-QAM transmitter. Each of two rails, I and Q, has its own pseudo-random bit source. That source yields one of four amplitude levels per symbol, so the pair of rails covers the sixteen points of a square constellation. A new symbol is drawn once every four clocks. Both rails then go through a raised-cosine interpolating filter that raises the rate by four and limits the spectrum. The result is one shaped I/Q sample per clock.

The filter is built as four polyphase branches of seven taps each, which together make a 28-tap response. A symbol strobe marks the first sample of every new symbol period. Alongside each sample, the block exports the symbol that currently sits at the centre of the filter. This lets downstream checking logic line up the symbols with the shaped waveform without tracking the filter's delay itself.

Top module: `qam16_shaper`

## Requirements
- R1: While reset is low, and until the first strobe, `sym_stb_o` is 0 and all sample and symbol outputs are 0.
- R2: `sym_stb_o` is first high in the cycle after the second rising clock edge that follows reset release. After that it is high exactly once in every 4 clocks.
- R3: Each rail holds a 16-bit shift register with feedback bit = b15^b13^b12^b10, shifted left with the feedback entering bit 0. The I rail starts from 16'hACE1 and the Q rail from 16'h1D0F. The register steps twice per symbol, and the register never becomes all zeros.
- R4: After the two steps, bits {b1,b0} of the new register value select the level. The mapping is Gray: 00 gives -3, 01 gives -1, 11 gives +1, 10 gives +3. Over a long run every one of the 16 (I,Q) pairs occurs.
- R5: In a strobe cycle, the exported symbol of each rail is the symbol that entered the filter three strobes earlier. It is 0 for the first three strobes.
- R6: In the strobe cycle of symbol n and the 3 cycles after it, the output for phase p (0..3) is sum over k=0..6 of s[n-k]·h[4k+p], where symbols before the first are 0.
- R7: The taps are h[j] = h[27-j], and h[0..13] = 5, 1, 1, 11, 23, 16, -26, -94, -137, -82, 119, 439, 777, 995.
- R8: The exported symbols change only in strobe cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_stb_o | output | 1 | High on the first sample of each symbol period |
| i_smp_o | output | 18 | Shaped I sample, signed |
| q_smp_o | output | 18 | Shaped Q sample, signed |
| i_sym_o | output | 3 | I symbol at the filter centre, signed |
| q_sym_o | output | 3 | Q symbol at the filter centre, signed |

## Verification
The bench builds the block with its default parameters: 4 phases, 7 taps per branch, 3-bit levels and 16-bit sources. At this size a run of 200 symbols visits every polyphase branch many times over, and every one of the sixteen constellation points. Each shaped sample is compared with a convolution that the bench computes from the exported symbols and its own copy of the coefficient list. The symbol stream is checked against an arithmetic model of both bit sources and the Gray map.

// File: rtl/qam16_pkg.sv
package qam16_pkg;

    localparam int UPS    = 4;
    localparam int TPB    = 7;
    localparam int NTAP   = UPS * TPB;
    localparam int COEF_W = 12;
    localparam int AMP_W  = 3;
    localparam int LFSR_W = 16;
    localparam int OUT_W  = COEF_W + AMP_W + $clog2(TPB);

    typedef logic signed [AMP_W-1:0]  amp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic [LFSR_W-1:0]        lfsr_t;

    // Half of a symmetric raised-cosine response, roll-off 0.5, Q10 scale.
    function automatic coef_t rc_coef(input int j);
        int m;
        m = (j < NTAP / 2) ? j : (NTAP - 1 - j);
        case (m)
            0:       return 12'sd5;
            1:       return 12'sd1;
            2:       return 12'sd1;
            3:       return 12'sd11;
            4:       return 12'sd23;
            5:       return 12'sd16;
            6:       return -12'sd26;
            7:       return -12'sd94;
            8:       return -12'sd137;
            9:       return -12'sd82;
            10:      return 12'sd119;
            11:      return 12'sd439;
            12:      return 12'sd777;
            13:      return 12'sd995;
            default: return 12'sd0;
        endcase
    endfunction

    function automatic amp_t gray_level(input logic [1:0] b);
        case (b)
            2'b00:   return -3'sd3;
            2'b01:   return -3'sd1;
            2'b11:   return 3'sd1;
            default: return 3'sd3;
        endcase
    endfunction

    function automatic lfsr_t lfsr_step(input lfsr_t l);
        return {l[LFSR_W-2:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    endfunction

endpackage

// File: rtl/qam16_rail.sv
module qam16_rail
    import qam16_pkg::*;
#(
    parameter lfsr_t SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output amp_t sym_o
);

    typedef struct packed {
        lfsr_t lfsr;
    } st_t;

    st_t   st_d, st_q;
    lfsr_t nxt;

    always_comb begin
        st_d  = st_q;
        nxt   = lfsr_step(lfsr_step(st_q.lfsr));
        sym_o = gray_level(nxt[1:0]);
        if (adv_i) begin
            st_d.lfsr = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lfsr <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lfsr != '0);

    a_r3_lfsr_moves: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> st_q.lfsr != $past(st_q.lfsr));

    a_r3_lfsr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(st_q.lfsr));

endmodule

// File: rtl/qam16_polyfir.sv
module qam16_polyfir
    import qam16_pkg::*;
#(
    parameter int P_UPS   = UPS,
    parameter int P_TPB   = TPB,
    parameter int P_OUT_W = OUT_W,
    parameter int CTR_IDX = (P_TPB - 1) / 2,
    localparam int PH_W   = (P_UPS > 1) ? $clog2(P_UPS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic [PH_W-1:0]           phase_i,
    input  amp_t                      sym_i,
    output logic signed [P_OUT_W-1:0] smp_o,
    output amp_t                      ctr_o
);

    typedef struct packed {
        logic [P_TPB-1:0][AMP_W-1:0] hist;
        logic signed [P_OUT_W-1:0]   smp;
        amp_t                        ctr;
    } st_t;

    st_t                       st_d, st_q;
    logic signed [P_OUT_W-1:0] acc;

    always_comb begin
        st_d = st_q;
        acc  = '0;
        for (int k = 0; k < P_TPB; k++) begin
            acc = acc + P_OUT_W'($signed(st_q.hist[k]))
                      * P_OUT_W'(rc_coef(P_UPS * k + int'(phase_i)));
        end
        st_d.smp = acc;
        st_d.ctr = amp_t'(st_q.hist[CTR_IDX]);
        if (load_i) begin
            st_d.hist[0] = sym_i;
            for (int k = 1; k < P_TPB; k++) begin
                st_d.hist[k] = st_q.hist[k-1];
            end
        end
        smp_o = st_q.smp;
        ctr_o = st_q.ctr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r5_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> st_q.hist[1] == $past(st_q.hist[0]));

    a_r5_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.hist));

endmodule

// File: rtl/qam16_shaper.sv
module qam16_shaper
    import qam16_pkg::*;
#(
    parameter int    P_UPS   = UPS,
    parameter int    P_TPB   = TPB,
    parameter int    P_OUT_W = OUT_W,
    parameter lfsr_t SEED_I  = 16'hACE1,
    parameter lfsr_t SEED_Q  = 16'h1D0F,
    localparam int   PH_W    = (P_UPS > 1) ? $clog2(P_UPS) : 1,
    localparam int   NRAIL   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic                      sym_stb_o,
    output logic signed [P_OUT_W-1:0] i_smp_o,
    output logic signed [P_OUT_W-1:0] q_smp_o,
    output logic signed [AMP_W-1:0]   i_sym_o,
    output logic signed [AMP_W-1:0]   q_sym_o
);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            stb;
    } st_t;

    st_t  st_d, st_q;
    logic load;

    amp_t                      sym_w [NRAIL];
    amp_t                      ctr_w [NRAIL];
    logic signed [P_OUT_W-1:0] smp_w [NRAIL];

    always_comb begin
        st_d      = st_q;
        load      = (st_q.phase == PH_W'(P_UPS - 1));
        st_d.phase = load ? '0 : st_q.phase + PH_W'(1);
        st_d.stb  = (st_q.phase == '0);
        sym_stb_o = st_q.stb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_W'(P_UPS - 1);
            st_q.stb   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar r = 0; r < NRAIL; r++) begin : g_rail
        qam16_rail #(
            .SEED (r == 0 ? SEED_I : SEED_Q)
        ) rail_i (
            .clk   (clk),
            .rst_n (rst_n),
            .adv_i (load),
            .sym_o (sym_w[r])
        );

        qam16_polyfir #(
            .P_UPS   (P_UPS),
            .P_TPB   (P_TPB),
            .P_OUT_W (P_OUT_W)
        ) fir_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .phase_i (st_q.phase),
            .sym_i   (sym_w[r]),
            .smp_o   (smp_w[r]),
            .ctr_o   (ctr_w[r])
        );
    end

    assign i_smp_o = smp_w[0];
    assign q_smp_o = smp_w[1];
    assign i_sym_o = ctr_w[0];
    assign q_sym_o = ctr_w[1];

    a_r2_stb_gap: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb_o |=> !sym_stb_o);

    a_r2_stb_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ##1 sym_stb_o);

    a_r8_sym_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_stb_o |-> ($stable(i_sym_o) && $stable(q_sym_o)));

endmodule

// File: tb/qam16_shaper_tb_top.sv
module qam16_shaper_tb_top;

    localparam int NSYM = 200;
    localparam int NCYC = 4 * NSYM + 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sym_stb_o;
    logic signed [17:0] i_smp_o, q_smp_o;
    logic signed [2:0]  i_sym_o, q_sym_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int ei [NSYM + 8];
    int eq [NSYM + 8];
    int yi [NSYM + 8][4];
    int yq [NSYM + 8][4];

    always #2 clk = ~clk;

    qam16_shaper dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_stb_o (sym_stb_o),
        .i_smp_o   (i_smp_o),
        .q_smp_o   (q_smp_o),
        .i_sym_o   (i_sym_o),
        .q_sym_o   (q_sym_o)
    );

    function automatic int tap(input int j);
        int half [14] = '{5, 1, 1, 11, 23, 16, -26, -94, -137, -82, 119, 439, 777, 995};
        return (j < 14) ? half[j] : half[27 - j];
    endfunction

    function automatic int glev(input int b);
        case (b)
            0:       return -3;
            1:       return -1;
            3:       return 1;
            default: return 3;
        endcase
    endfunction

    function automatic logic [15:0] stp(input logic [15:0] l);
        return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int sc;
        int p;
        int first;
        int lastc;
        logic [15:0] li, lq;
        int si [NSYM];
        int sq [NSYM];
        bit seen [16];
        int nseen;
        bit lev_i [4];
        bit lev_q [4];

        sc = -1;
        p = 0;
        first = -1;
        lastc = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        chk(sym_stb_o == 1'b0, "R1 stb in reset", int'(sym_stb_o), 0);
        chk(i_smp_o == 0 && q_smp_o == 0, "R1 samples in reset", int'(i_smp_o), 0);
        chk(i_sym_o == 0 && q_sym_o == 0, "R1 symbols in reset", int'(i_sym_o), 0);
        rst_n = 1'b1;

        for (int c = 1; c <= NCYC; c++) begin
            @(negedge clk);
            if (sym_stb_o) begin
                if (sc < 0) begin
                    first = c;
                end else begin
                    // R2: spacing of strobes
                    chk(c - lastc == 4, "R2 strobe spacing", c - lastc, 4);
                end
                lastc = c;
                sc++;
                p = 0;
                if (sc < NSYM + 8) begin
                    ei[sc] = int'(i_sym_o);
                    eq[sc] = int'(q_sym_o);
                end
            end else begin
                p++;
                if (sc < 0) begin
                    // R1: quiet until the first strobe
                    chk(i_smp_o == 0 && q_smp_o == 0 && i_sym_o == 0 && q_sym_o == 0,
                        "R1 quiet before first strobe", int'(i_smp_o), 0);
                end else if (sc < NSYM + 8) begin
                    // R8: exported symbols hold between strobes
                    chk(int'(i_sym_o) == ei[sc] && int'(q_sym_o) == eq[sc],
                        "R8 symbol hold", int'(i_sym_o), ei[sc]);
                end
            end
            if (sc >= 0 && sc < NSYM + 8 && p < 4) begin
                yi[sc][p] = int'(i_smp_o);
                yq[sc][p] = int'(q_smp_o);
            end
        end

        // R2: first strobe position
        chk(first == 2, "R2 first strobe cycle", first, 2);

        // R3, R4: symbol model
        li = 16'hACE1;
        lq = 16'h1D0F;
        for (int n = 0; n < NSYM; n++) begin
            li = stp(stp(li));
            lq = stp(stp(lq));
            chk(li != 0 && lq != 0, "R3 register nonzero", int'(li), 1);
            si[n] = glev(int'(li[1:0]));
            sq[n] = glev(int'(lq[1:0]));
        end

        // R5: exported symbols are the model delayed by three strobes
        for (int n = 0; n < NSYM; n++) begin
            int xi;
            int xq;
            xi = (n < 3) ? 0 : si[n - 3];
            xq = (n < 3) ? 0 : sq[n - 3];
            chk(ei[n] == xi, "R5 R3 R4 exported I symbol", ei[n], xi);
            chk(eq[n] == xq, "R5 R3 R4 exported Q symbol", eq[n], xq);
        end

        // R4: every constellation point and level reached
        nseen = 0;
        for (int n = 0; n < NSYM; n++) begin
            int ki;
            int kq;
            ki = (si[n] + 3) / 2;
            kq = (sq[n] + 3) / 2;
            lev_i[ki] = 1'b1;
            lev_q[kq] = 1'b1;
            if (n >= 3 && ei[n] == si[n - 3] && eq[n] == sq[n - 3]) begin
                int pi;
                int pq;
                pi = (ei[n] + 3) / 2;
                pq = (eq[n] + 3) / 2;
                if (!seen[pi * 4 + pq]) nseen++;
                seen[pi * 4 + pq] = 1'b1;
            end
        end
        chk(nseen == 16, "R4 all sixteen points", nseen, 16);
        chk(lev_i[0] && lev_i[1] && lev_i[2] && lev_i[3], "R4 I levels", 0, 1);
        chk(lev_q[0] && lev_q[1] && lev_q[2] && lev_q[3], "R4 Q levels", 0, 1);

        // R6, R7: polyphase convolution from exported symbols
        for (int n = 0; n + 3 < NSYM; n++) begin
            for (int ph = 0; ph < 4; ph++) begin
                int xi;
                int xq;
                xi = 0;
                xq = 0;
                for (int k = 0; k < 7; k++) begin
                    int j;
                    j = n + 3 - k;
                    if (j >= 0) begin
                        xi += ei[j] * tap(4 * k + ph);
                        xq += eq[j] * tap(4 * k + ph);
                    end
                end
                chk(yi[n][ph] == xi, "R6 R7 I sample", yi[n][ph], xi);
                chk(yq[n][ph] == xq, "R6 R7 Q sample", yq[n][ph], xq);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule